// File: doc/BRIEF.md
# Packed Decimal Byte Adder with Bias-and-Correct Adjust

This block adds two packed decimal bytes, each holding a tens digit and a units digit, together with a one-bit carry-in. It returns a packed decimal sum byte and a decimal carry-out. The digits are never compared against nine. Operand A is first offset by six in every digit. Operand B and the carry-in are then added in plain binary, and two carries come out of that addition: the one that crosses between the digits and the one that leaves the byte. These two carries select one of four constant correction bytes. The correction is added with wrap-around, and its carry is dropped.

Results are registered, so the sum and carry-out appear one clock after the operands are sampled. A synchronous, active-high reset clears both outputs. Operands are assumed to be valid decimal digits. Subtraction and chaining across bytes are handled outside the block.

Top module: `bcdb_adder`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `sum_o` becomes 0x00 and `cout_o` becomes 0 at that edge.
- R2: For valid decimal operands, each four-bit digit of `sum_o` is at most 9.
- R3: The outputs are registered. They reflect the operands and carry-in sampled at the previous rising edge. Input changes between edges have no effect until the next edge.
- R4: For valid operands, 100·`cout_o` + 10·`sum_o[7:4]` + `sum_o[3:0]` equals A + B + `cin_i` in decimal.
- R5: `cout_o` is 1 exactly when A + B + `cin_i` is at least 100. This is the carry out of bit 7 of the binary addition of the biased A and B.
- R6: `cin_i` adds one at the units digit. For example, 0x99 + 0x00 with carry-in 1 gives sum 0x00 and carry-out 1.
- R7: A units-digit sum of ten or more carries into the tens digit. For example, 0x09 + 0x01 gives 0x10, and 0x55 + 0x55 with carry-in 1 gives 0x11 with carry-out 1.
- R8: Digit order: bits [3:0] of each operand and of `sum_o` hold the units digit, and bits [7:4] hold the tens digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| opa_i | input | 8 | Packed decimal operand A |
| opb_i | input | 8 | Packed decimal operand B |
| cin_i | input | 1 | Decimal carry-in |
| sum_o | output | 8 | Registered packed decimal sum |
| cout_o | output | 1 | Registered decimal carry-out |

## Verification
In a single addition, the carry between the digits and the carry out of the byte can both be set, and together they pick the correction entry. An interdigit carry can also feed a tens-digit overflow, as in 0x99 + 0x01 or 0x55 + 0x55 + 1. Both cases are provoked directly. They are also covered by an exhaustive sweep of all ten thousand digit-pair combinations, each with both carry-in values. Every result is compared against an integer decimal sum computed in the bench and re-encoded into packed digits.

// File: rtl/bcdb_pkg.sv
package bcdb_pkg;
  localparam int NIB_W  = 4;
  localparam int N_DIG  = 2;
  localparam int BYTE_W = NIB_W * N_DIG;
  localparam int RADIX  = 10;
  localparam int SKIP   = (1 << NIB_W) - RADIX;

  typedef logic [BYTE_W-1:0] byte_t;

  // Offset added to operand A: SKIP in every digit position.
  function automatic byte_t bias_const();
    byte_t r;
    r = '0;
    for (int i = 0; i < N_DIG; i++) r[i*NIB_W +: NIB_W] = NIB_W'(SKIP);
    return r;
  endfunction

  // Four-entry correction table selected by {byte carry, digit carry}.
  function automatic byte_t corr_lookup(input logic carry, input logic aux);
    case ({carry, aux})
      2'b00:   return 8'h9A;
      2'b01:   return 8'hA0;
      2'b10:   return 8'hFA;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit is_dec(input byte_t v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic int dec_val(input byte_t v);
    return int'(v[7:4]) * RADIX + int'(v[3:0]);
  endfunction
endpackage

// File: rtl/bcdb_bias.sv
module bcdb_bias
  import bcdb_pkg::*;
(
  input  byte_t a_i,
  output byte_t biased_o
);
  assign biased_o = a_i + bias_const();
endmodule

// File: rtl/bcdb_chain.sv
module bcdb_chain
  import bcdb_pkg::*;
(
  input  byte_t             x_i,
  input  byte_t             y_i,
  input  logic              cin_i,
  output byte_t             raw_o,
  output logic [N_DIG-1:0]  dcar_o
);
  logic [N_DIG:0] ch;
  assign ch[0] = cin_i;

  for (genvar g = 0; g < N_DIG; g++) begin : g_dig
    assign {ch[g+1], raw_o[g*NIB_W +: NIB_W]} =
      {1'b0, x_i[g*NIB_W +: NIB_W]} + {1'b0, y_i[g*NIB_W +: NIB_W]}
      + {{NIB_W{1'b0}}, ch[g]};
  end

  assign dcar_o = ch[N_DIG:1];
endmodule

// File: rtl/bcdb_adjust.sv
module bcdb_adjust
  import bcdb_pkg::*;
(
  input  byte_t raw_i,
  input  logic  carry_i,
  input  logic  aux_i,
  output byte_t adj_o
);
  // Correction carry out of bit 7 is dropped by the wrap of the byte width.
  assign adj_o = raw_i + corr_lookup(carry_i, aux_i);

  // R4: both digits already carried, so nothing may change.
  always_comb begin
    if (carry_i && aux_i)
      a_r4_no_corr: assert (adj_o == raw_i);
  end
endmodule

// File: rtl/bcdb_adder.sv
module bcdb_adder
  import bcdb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [BYTE_W-1:0] opa_i,
  input  logic [BYTE_W-1:0] opb_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] sum_o,
  output logic              cout_o
);
  byte_t            biased, raw, adj;
  logic [N_DIG-1:0] dcar;

  bcdb_bias u_bias (
    .a_i      (opa_i),
    .biased_o (biased)
  );

  bcdb_chain u_chain (
    .x_i    (biased),
    .y_i    (opb_i),
    .cin_i  (cin_i),
    .raw_o  (raw),
    .dcar_o (dcar)
  );

  bcdb_adjust u_adjust (
    .raw_i   (raw),
    .carry_i (dcar[N_DIG-1]),
    .aux_i   (dcar[0]),
    .adj_o   (adj)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= adj;
      cout_o <= dcar[N_DIG-1];
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk_i)
    rst_i |=> (sum_o == '0 && !cout_o));

  a_r2_digit_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && is_dec($past(opa_i)) && is_dec($past(opb_i)))
      |-> is_dec(sum_o));

  a_r4_decimal_value: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && is_dec($past(opa_i)) && is_dec($past(opb_i)))
      |-> (dec_val(sum_o) + 100 * int'(cout_o) ==
           dec_val($past(opa_i)) + dec_val($past(opb_i)) + int'($past(cin_i))));

  a_r5_carry_out: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && is_dec($past(opa_i)) && is_dec($past(opb_i)))
      |-> (cout_o == ((dec_val($past(opa_i)) + dec_val($past(opb_i))
                       + int'($past(cin_i))) >= 100)));

  a_r7_digit_carry: assert property (@(posedge clk_i) disable iff (rst_i)
    (is_dec(opa_i) && is_dec(opb_i))
      |-> (dcar[0] == ((int'(opa_i[3:0]) + int'(opb_i[3:0]) + int'(cin_i)) >= RADIX)));
endmodule

// File: tb/bcdb_adder_bench.sv
`timescale 1ns/1ps
module bcdb_adder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic       cin = 1'b0;
  logic [7:0] sum;
  logic       cout;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  bcdb_adder u_bcdb_adder (
    .clk_i  (clk),
    .rst_i  (rst),
    .opa_i  (opa),
    .opb_i  (opb),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  function automatic logic [7:0] enc(input int v);
    return {4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got cout/sum=%03h expected %03h", tag, act, exp);
    end
  endtask

  // One operation: drive at a falling edge, sample at the next falling edge.
  task automatic apply(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic c, input logic [8:0] exp);
    @(negedge clk);
    opa = a; opb = b; cin = c;
    @(negedge clk);
    check(tag, {cout, sum}, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 initial reset", {cout, sum}, 9'h000);
    rst = 1'b0;
    apply("R1 prior load", 8'h99, 8'h99, 1'b1, 9'h199);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", {cout, sum}, 9'h000);
    rst = 1'b0;
  endtask

  task automatic t_corners();
    apply("R6 carry-in wraps", 8'h99, 8'h00, 1'b1, 9'h100);
    apply("R6 carry-in only", 8'h00, 8'h00, 1'b1, 9'h001);
    apply("R7 units carry", 8'h09, 8'h01, 1'b0, 9'h010);
    apply("R7 both carries", 8'h55, 8'h55, 1'b1, 9'h111);
    apply("R7 ripple to out", 8'h99, 8'h01, 1'b0, 9'h100);
    apply("R5 max sum", 8'h99, 8'h99, 1'b1, 9'h199);
    apply("R8 digit order", 8'h12, 8'h30, 1'b0, 9'h042);
    apply("R2 tens only carry", 8'h50, 8'h60, 1'b0, 9'h110);
  endtask

  task automatic t_latency();
    @(negedge clk);
    opa = 8'h27; opb = 8'h15; cin = 1'b0;
    @(posedge clk);
    #2;
    opa = 8'h80; opb = 8'h80; cin = 1'b1;
    @(negedge clk);
    check("R3 mid-cycle change ignored", {cout, sum}, 9'h042);
    @(negedge clk);
    check("R3 next edge takes new", {cout, sum}, 9'h161);
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        for (int c = 0; c < 2; c++) begin
          int t = a + b + c;
          apply("R4/R5/R2 sweep", enc(a), enc(b), c[0], {t >= 100, enc(t % 100)});
        end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_corners();
    t_latency();
    t_sweep();
    done = 1'b1;
    report();
  end

  initial begin
    #(20ns * 60000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule